// File: doc/BRIEF.md
# Multiplexed Byte-Bus Register Slave

This block is the register front end of a card-interface controller. A host talks to it over eight shared lines that carry both a register index and data. A select line says which of the two a transfer carries. Chip select, read and write strobes are active low. Every register access takes two bus transfers. The first is a write with the select line high, which loads the register index. The second is a read or write with the select line low, which moves one byte to or from that register.

Most registers are held inside the block. Two of them are not: the card data register (0x06) and the filter data register (0x0A). Accesses to these are passed to a slow sub-block through a request/acknowledge port. The address sent with the request comes from the matching low/high address register pair. While such an access is outstanding, the active-low ready output is driven high. The block also watches two card-detect inputs. When an enabled slot changes state, it drives an active-low interrupt, which the host clears by reading the interrupt control register.

Top module: `mbus_slave`

## Requirements
- R1: A write with `bus_ad_sel` high latches `bus_din` as the register index. The index stays in use for every later data transfer until the next address write.
- R2: The registers at 0x01, 0x04, 0x05, 0x08, 0x09, 0x0C and 0x0D reset to 0x00. Each reads back the last byte written to it. 0x01, 0x07, 0x0C and 0x0D drive `ctl2_o`, `ctl_o`, `div_a_o` and `div_b_o`.
- R3: Index 0x0F always reads the `REVISION` parameter (default 0x21). Writes to it have no effect.
- R4: Indices with no register (0x02, 0x03, 0x0B, 0x0E, 0x10 to 0xFF) read as 0x00. Writes to them change no register.
- R5: A read of a held register puts its value on `bus_dout` in the cycle after the strobe's first active edge. `bus_dout_en` is high while the read strobe stays low and falls once the strobe is released.
- R6: A data transfer at 0x06 raises `fwd_req` with `fwd_sel`=0 and `fwd_addr`={reg 0x05, reg 0x04}. A data transfer at 0x0A raises `fwd_req` with `fwd_sel`=1 and `fwd_addr`={reg 0x09, reg 0x08}. `fwd_we` is 1 for writes, and `fwd_wdata` carries the byte written.
- R7: `bus_rdy_n` is high from the cycle after a forwarded transfer starts until the cycle after `fwd_ack`. For a read, `bus_dout` holds `fwd_rdata` when `bus_rdy_n` falls. Ready stays low for all other transfers.
- R8: Bit 2 of the interrupt control register (0x00) enables slot 0, and bit 6 enables slot 1, so writing 0x44 enables both. A change on an enabled `card_det_n` bit sets that slot's pending flag, and `irq_n` goes low two clock edges after the input changes.
- R9: A read of 0x00 returns the stored enable bits in [7:2] and the pending flags in [1:0] (bit 0 = slot 0). The read clears the flags and releases `irq_n`. Writes to bits [1:0] are ignored.
- R10: A change on a slot whose enable bit is clear raises no interrupt.
- R11: Register 0x07 stores bits [7:2]. Bits [1:0] read the sampled `card_det_n` inputs, and writes to them are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_cs_n | input | 1 | Chip select, active low |
| bus_wr_n | input | 1 | Write strobe, active low |
| bus_rd_n | input | 1 | Read strobe, active low |
| bus_ad_sel | input | 1 | 1 = index transfer, 0 = data transfer |
| bus_din | input | 8 | Byte from host |
| bus_dout | output | 8 | Byte to host |
| bus_dout_en | output | 1 | Output enable for `bus_dout` |
| bus_rdy_n | output | 1 | Ready, active low (high = wait) |
| irq_n | output | 1 | Interrupt, active low |
| card_det_n | input | 2 | Card detect per slot, active low |
| ctl_o | output | 8 | Bus control register (0x07) |
| ctl2_o | output | 8 | Bus control 2 register (0x01) |
| div_a_o | output | 8 | Stream clock divider A (0x0C) |
| div_b_o | output | 8 | Stream clock divider B (0x0D) |
| fwd_req | output | 1 | Forwarded access pending |
| fwd_we | output | 1 | Forwarded access is a write |
| fwd_sel | output | 1 | 0 = card data, 1 = filter data |
| fwd_addr | output | 16 | Address for the forwarded access |
| fwd_wdata | output | 8 | Write byte for the forwarded access |
| fwd_ack | input | 1 | Sub-block completion |
| fwd_rdata | input | 8 | Sub-block read byte |

## Verification
The assertions rely on the host never driving read and write low together under chip select, and never starting a new transfer while ready is high. They also rely on the sub-block raising `fwd_ack` only while `fwd_req` is high. The bench keeps within these limits. It drives one strobe at a time and holds each strobe until `bus_rdy_n` reads low. It releases the bus for a full cycle between transfers. Its sub-block model answers only a pending request, after a fixed delay.

// File: rtl/mbus_pkg.sv
package mbus_pkg;

    localparam int BYTE_W = 8;
    localparam int SLOTS  = 2;
    localparam int ADDR_W = 2 * BYTE_W;

    typedef logic [BYTE_W-1:0] byte_t;

    // register indices; 0x06 and 0x0A are serviced by the slow sub-block
    typedef enum byte_t {
        RI_INT    = 8'h00,
        RI_CTL2   = 8'h01,
        RI_CA_LO  = 8'h04,
        RI_CA_HI  = 8'h05,
        RI_CA_DAT = 8'h06,
        RI_CTL    = 8'h07,
        RI_FA_LO  = 8'h08,
        RI_FA_HI  = 8'h09,
        RI_FA_DAT = 8'h0A,
        RI_DIV_A  = 8'h0C,
        RI_DIV_B  = 8'h0D,
        RI_REV    = 8'h0F
    } reg_idx_e;

    typedef enum logic {F_IDLE, F_WAIT} fwd_st_e;

    // one host transfer, valid for a single cycle when start is high
    typedef struct packed {
        logic  start;
        logic  is_addr;
        logic  is_wr;
        byte_t idx;
        byte_t wdata;
    } bus_acc_t;

    localparam byte_t LOW_MASK   = byte_t'((1 << SLOTS) - 1);
    localparam byte_t STORE_MASK = ~LOW_MASK;

    function automatic logic idx_is_fwd(byte_t i);
        return (i == RI_CA_DAT) || (i == RI_FA_DAT);
    endfunction

    function automatic logic idx_is_mapped(byte_t i);
        case (i)
            RI_INT, RI_CTL2, RI_CA_LO, RI_CA_HI, RI_CA_DAT, RI_CTL,
            RI_FA_LO, RI_FA_HI, RI_FA_DAT, RI_DIV_A, RI_DIV_B, RI_REV:
                return 1'b1;
            default:
                return 1'b0;
        endcase
    endfunction

    // interrupt enable bit position of a slot (2, 6, ...)
    function automatic int en_bit(int s);
        return 2 + 4 * s;
    endfunction

endpackage

// File: rtl/mbus_phase.sv
module mbus_phase
    import mbus_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     cs_n,
    input  logic     wr_n,
    input  logic     rd_n,
    input  logic     ad_sel,
    input  byte_t    din,
    output bus_acc_t acc,
    output logic     act
);

    logic  act_q;
    byte_t idx_q;
    logic  start;

    assign act   = !cs_n && (!wr_n || !rd_n);
    assign start = act && !act_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            act_q <= 1'b0;
            idx_q <= '0;
        end else begin
            act_q <= act;
            if (start && ad_sel && !wr_n)
                idx_q <= din;
        end
    end

    always_comb begin
        acc.start   = start;
        acc.is_addr = ad_sel;
        acc.is_wr   = !wr_n;
        acc.idx     = idx_q;
        acc.wdata   = din;
    end

    // input rule: one strobe at a time
    p_strobe_excl_r5: assert property (@(posedge clk) disable iff (rst)
        !cs_n |-> (wr_n || rd_n));

    // data transfers never disturb the latched index
    p_idx_hold_r1: assert property (@(posedge clk) disable iff (rst)
        (start && !ad_sel) |=> $stable(idx_q));

endmodule

// File: rtl/mbus_regfile.sv
module mbus_regfile
    import mbus_pkg::*;
#(
    parameter byte_t REVISION = 8'h21
) (
    input  logic             clk,
    input  logic             rst,
    input  bus_acc_t         acc,
    input  logic [SLOTS-1:0] det_q,
    input  logic [SLOTS-1:0] pend,
    output byte_t            rdata,
    output logic [SLOTS-1:0] int_en,
    output byte_t            ctl_o,
    output byte_t            ctl2_o,
    output byte_t            div_a_o,
    output byte_t            div_b_o,
    output logic [ADDR_W-1:0] ca_addr,
    output logic [ADDR_W-1:0] fa_addr
);

    byte_t int_ctl, ctl, ctl2, ca_lo, ca_hi, fa_lo, fa_hi, div_a, div_b;
    logic  wr_en;
    logic [9*BYTE_W-1:0] snap;

    assign wr_en = acc.start && !acc.is_addr && acc.is_wr;

    always_ff @(posedge clk) begin
        if (rst) begin
            int_ctl <= '0; ctl <= '0; ctl2 <= '0;
            ca_lo   <= '0; ca_hi <= '0; fa_lo <= '0; fa_hi <= '0;
            div_a   <= '0; div_b <= '0;
        end else if (wr_en) begin
            case (acc.idx)
                RI_INT:   int_ctl <= acc.wdata & STORE_MASK;
                RI_CTL2:  ctl2    <= acc.wdata;
                RI_CA_LO: ca_lo   <= acc.wdata;
                RI_CA_HI: ca_hi   <= acc.wdata;
                RI_CTL:   ctl     <= acc.wdata & STORE_MASK;
                RI_FA_LO: fa_lo   <= acc.wdata;
                RI_FA_HI: fa_hi   <= acc.wdata;
                RI_DIV_A: div_a   <= acc.wdata;
                RI_DIV_B: div_b   <= acc.wdata;
                default:  ;
            endcase
        end
    end

    always_comb begin
        rdata = '0;
        case (acc.idx)
            RI_INT:   rdata = {int_ctl[BYTE_W-1:SLOTS], pend};
            RI_CTL2:  rdata = ctl2;
            RI_CA_LO: rdata = ca_lo;
            RI_CA_HI: rdata = ca_hi;
            RI_CTL:   rdata = {ctl[BYTE_W-1:SLOTS], det_q};
            RI_FA_LO: rdata = fa_lo;
            RI_FA_HI: rdata = fa_hi;
            RI_DIV_A: rdata = div_a;
            RI_DIV_B: rdata = div_b;
            RI_REV:   rdata = REVISION;
            default:  rdata = '0;
        endcase
    end

    for (genvar s = 0; s < SLOTS; s++) begin : g_en
        assign int_en[s] = int_ctl[en_bit(s)];
    end

    assign ctl_o   = ctl;
    assign ctl2_o  = ctl2;
    assign div_a_o = div_a;
    assign div_b_o = div_b;
    assign ca_addr = {ca_hi, ca_lo};
    assign fa_addr = {fa_hi, fa_lo};
    assign snap    = {int_ctl, ctl, ctl2, ca_lo, ca_hi, fa_lo, fa_hi, div_a, div_b};

    p_unmapped_wr_r4: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !idx_is_mapped(acc.idx)) |=> $stable(snap));

    p_rev_wr_r3: assert property (@(posedge clk) disable iff (rst)
        (wr_en && acc.idx == RI_REV) |=> $stable(snap));

endmodule

// File: rtl/mbus_irq.sv
module mbus_irq
    import mbus_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [SLOTS-1:0] card_det_n,
    input  logic [SLOTS-1:0] int_en,
    input  logic             clr,
    output logic [SLOTS-1:0] det_q,
    output logic [SLOTS-1:0] pend,
    output logic             irq_n
);

    logic [SLOTS-1:0] det_p;
    logic [SLOTS-1:0] chg;

    for (genvar s = 0; s < SLOTS; s++) begin : g_chg
        assign chg[s] = (det_q[s] ^ det_p[s]) && int_en[s];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            det_q <= '1;
            det_p <= '1;
            pend  <= '0;
        end else begin
            det_q <= card_det_n;
            det_p <= det_q;
            for (int s = 0; s < SLOTS; s++) begin
                if (chg[s])
                    pend[s] <= 1'b1;
                else if (clr)
                    pend[s] <= 1'b0;
            end
        end
    end

    assign irq_n = ~|pend;

    p_ack_release_r9: assert property (@(posedge clk) disable iff (rst)
        (clr && !(|chg)) |=> irq_n);

    for (genvar s = 0; s < SLOTS; s++) begin : g_chk
        p_pend_cause_r10: assert property (@(posedge clk) disable iff (rst)
            $rose(pend[s]) |-> $past(int_en[s] && (det_q[s] != det_p[s])));
    end

endmodule

// File: rtl/mbus_fwd.sv
module mbus_fwd
    import mbus_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  bus_acc_t          acc,
    input  logic [ADDR_W-1:0] ca_addr,
    input  logic [ADDR_W-1:0] fa_addr,
    input  logic              fwd_ack,
    output logic              fwd_req,
    output logic              fwd_we,
    output logic              fwd_sel,
    output logic [ADDR_W-1:0] fwd_addr,
    output byte_t             fwd_wdata,
    output logic              rd_load
);

    fwd_st_e st;
    logic    start_fwd;
    logic    pick_filt;

    assign start_fwd = acc.start && !acc.is_addr && idx_is_fwd(acc.idx);
    assign pick_filt = (acc.idx == RI_FA_DAT);

    always_ff @(posedge clk) begin
        if (rst) begin
            st        <= F_IDLE;
            fwd_we    <= 1'b0;
            fwd_sel   <= 1'b0;
            fwd_addr  <= '0;
            fwd_wdata <= '0;
        end else begin
            case (st)
                F_IDLE: if (start_fwd) begin
                    st        <= F_WAIT;
                    fwd_we    <= acc.is_wr;
                    fwd_sel   <= pick_filt;
                    fwd_addr  <= pick_filt ? fa_addr : ca_addr;
                    fwd_wdata <= acc.wdata;
                end
                F_WAIT: if (fwd_ack) st <= F_IDLE;
                default: st <= F_IDLE;
            endcase
        end
    end

    assign fwd_req = (st == F_WAIT);
    assign rd_load = fwd_req && fwd_ack && !fwd_we;

    p_ack_legal_r7: assert property (@(posedge clk) disable iff (rst)
        fwd_ack |-> fwd_req);

    p_no_start_busy_r7: assert property (@(posedge clk) disable iff (rst)
        acc.start |-> !fwd_req);

    p_req_start_r6: assert property (@(posedge clk) disable iff (rst)
        start_fwd |=> fwd_req);

    p_req_hold_r6: assert property (@(posedge clk) disable iff (rst)
        (fwd_req && !fwd_ack) |=> (fwd_req && $stable(fwd_addr) && $stable(fwd_we)));

endmodule

// File: rtl/mbus_slave.sv
module mbus_slave
    import mbus_pkg::*;
#(
    parameter byte_t REVISION = 8'h21
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_cs_n,
    input  logic              bus_wr_n,
    input  logic              bus_rd_n,
    input  logic              bus_ad_sel,
    input  logic [BYTE_W-1:0] bus_din,
    output logic [BYTE_W-1:0] bus_dout,
    output logic              bus_dout_en,
    output logic              bus_rdy_n,
    output logic              irq_n,
    input  logic [SLOTS-1:0]  card_det_n,
    output logic [BYTE_W-1:0] ctl_o,
    output logic [BYTE_W-1:0] ctl2_o,
    output logic [BYTE_W-1:0] div_a_o,
    output logic [BYTE_W-1:0] div_b_o,
    output logic              fwd_req,
    output logic              fwd_we,
    output logic              fwd_sel,
    output logic [ADDR_W-1:0] fwd_addr,
    output logic [BYTE_W-1:0] fwd_wdata,
    input  logic              fwd_ack,
    input  logic [BYTE_W-1:0] fwd_rdata
);

    bus_acc_t          acc;
    logic              act;
    byte_t             rdata;
    logic [SLOTS-1:0]  int_en, det_q, pend;
    logic [ADDR_W-1:0] ca_addr, fa_addr;
    logic              rd_load, clr, local_rd;
    byte_t             dout_q;
    logic              dout_v;

    mbus_phase u_phase (
        .clk(clk), .rst(rst), .cs_n(bus_cs_n), .wr_n(bus_wr_n), .rd_n(bus_rd_n),
        .ad_sel(bus_ad_sel), .din(bus_din), .acc(acc), .act(act)
    );

    mbus_regfile #(.REVISION(REVISION)) u_regs (
        .clk(clk), .rst(rst), .acc(acc), .det_q(det_q), .pend(pend), .rdata(rdata),
        .int_en(int_en), .ctl_o(ctl_o), .ctl2_o(ctl2_o), .div_a_o(div_a_o),
        .div_b_o(div_b_o), .ca_addr(ca_addr), .fa_addr(fa_addr)
    );

    mbus_irq u_irq (
        .clk(clk), .rst(rst), .card_det_n(card_det_n), .int_en(int_en), .clr(clr),
        .det_q(det_q), .pend(pend), .irq_n(irq_n)
    );

    mbus_fwd u_fwd (
        .clk(clk), .rst(rst), .acc(acc), .ca_addr(ca_addr), .fa_addr(fa_addr),
        .fwd_ack(fwd_ack), .fwd_req(fwd_req), .fwd_we(fwd_we), .fwd_sel(fwd_sel),
        .fwd_addr(fwd_addr), .fwd_wdata(fwd_wdata), .rd_load(rd_load)
    );

    assign local_rd = acc.start && !acc.is_addr && !acc.is_wr && !idx_is_fwd(acc.idx);
    assign clr      = acc.start && !acc.is_addr && !acc.is_wr && (acc.idx == RI_INT);

    always_ff @(posedge clk) begin
        if (rst) begin
            dout_q <= '0;
            dout_v <= 1'b0;
        end else if (local_rd) begin
            dout_q <= rdata;
            dout_v <= 1'b1;
        end else if (rd_load) begin
            dout_q <= fwd_rdata;
            dout_v <= 1'b1;
        end else if (!act) begin
            dout_v <= 1'b0;
        end
    end

    assign bus_dout    = dout_q;
    assign bus_dout_en = dout_v && !bus_rd_n && !bus_cs_n;
    assign bus_rdy_n   = fwd_req;

    p_rd_valid_r5: assert property (@(posedge clk) disable iff (rst)
        local_rd |=> dout_v);

    p_rdy_cause_r7: assert property (@(posedge clk) disable iff (rst)
        $rose(bus_rdy_n) |-> $past(acc.start && !acc.is_addr && idx_is_fwd(acc.idx)));

endmodule

// File: tb/test_mbus_slave.sv
module test_mbus_slave;

    localparam int    CLK_PERIOD = 10;
    localparam int    ACK_DLY    = 3;
    localparam [7:0]  REV_EXP    = 8'h21;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_cs_n = 1'b1, bus_wr_n = 1'b1, bus_rd_n = 1'b1, bus_ad_sel = 1'b0;
    logic [7:0]  bus_din = '0;
    logic [7:0]  bus_dout;
    logic        bus_dout_en, bus_rdy_n, irq_n;
    logic [1:0]  card_det_n = 2'b11;
    logic [7:0]  ctl_o, ctl2_o, div_a_o, div_b_o;
    logic        fwd_req, fwd_we, fwd_sel;
    logic [15:0] fwd_addr;
    logic [7:0]  fwd_wdata;
    logic        fwd_ack = 1'b0;
    logic [7:0]  fwd_rdata = '0;

    int n_chk = 0, n_bad = 0;
    bit done = 0;

    // values seen by the sub-block model
    int          fcnt = 0, n_fwd = 0;
    logic        log_sel, log_we;
    logic [15:0] log_addr;
    logic [7:0]  log_wdata;
    logic        first_rdy, last_en;

    always #(CLK_PERIOD/2) clk = ~clk;

    mbus_slave i_mbus_slave (
        .clk(clk), .rst(rst), .bus_cs_n(bus_cs_n), .bus_wr_n(bus_wr_n),
        .bus_rd_n(bus_rd_n), .bus_ad_sel(bus_ad_sel), .bus_din(bus_din),
        .bus_dout(bus_dout), .bus_dout_en(bus_dout_en), .bus_rdy_n(bus_rdy_n),
        .irq_n(irq_n), .card_det_n(card_det_n), .ctl_o(ctl_o), .ctl2_o(ctl2_o),
        .div_a_o(div_a_o), .div_b_o(div_b_o), .fwd_req(fwd_req), .fwd_we(fwd_we),
        .fwd_sel(fwd_sel), .fwd_addr(fwd_addr), .fwd_wdata(fwd_wdata),
        .fwd_ack(fwd_ack), .fwd_rdata(fwd_rdata)
    );

    // slow sub-block model: answers a pending request after ACK_DLY cycles
    always @(negedge clk) begin
        if (fwd_req) begin
            if (fcnt == ACK_DLY) begin
                fwd_ack   = 1'b1;
                fwd_rdata = fwd_addr[7:0] ^ 8'h5A ^ {7'd0, fwd_sel};
                log_sel   = fwd_sel;  log_we = fwd_we;
                log_addr  = fwd_addr; log_wdata = fwd_wdata;
                n_fwd++;
            end else begin
                fwd_ack = 1'b0;
            end
            fcnt++;
        end else begin
            fcnt    = 0;
            fwd_ack = 1'b0;
        end
    end

    task automatic check(input bit ok, input string req, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: got 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic bus_cycle(input logic sel, input logic wr, input logic [7:0] d, output logic [7:0] q);
        @(negedge clk);
        bus_cs_n = 1'b0; bus_ad_sel = sel; bus_din = d;
        if (wr) bus_wr_n = 1'b0; else bus_rd_n = 1'b0;
        @(negedge clk);
        first_rdy = bus_rdy_n;
        while (bus_rdy_n) @(negedge clk);
        q = bus_dout;
        last_en = bus_dout_en;
        bus_cs_n = 1'b1; bus_wr_n = 1'b1; bus_rd_n = 1'b1; bus_ad_sel = 1'b0;
    endtask

    task automatic wr_reg(input logic [7:0] idx, input logic [7:0] d);
        logic [7:0] q;
        bus_cycle(1'b1, 1'b1, idx, q);
        bus_cycle(1'b0, 1'b1, d, q);
    endtask

    task automatic rd_reg(input logic [7:0] idx, output logic [7:0] q);
        logic [7:0] t;
        bus_cycle(1'b1, 1'b1, idx, t);
        bus_cycle(1'b0, 1'b0, 8'h00, q);
    endtask

    task automatic t_reset;
        logic [7:0] q;
        check(irq_n == 1'b1, "R8 reset irq_n", 16'(irq_n), 16'h1);
        check(bus_rdy_n == 1'b0, "R7 reset rdy_n", 16'(bus_rdy_n), 16'h0);
        check(bus_dout_en == 1'b0, "R5 reset dout_en", 16'(bus_dout_en), 16'h0);
        check(div_a_o == 8'h00, "R2 reset div_a", 16'(div_a_o), 16'h0);
        rd_reg(8'h01, q);
        check(q == 8'h00, "R2 reset reg01", 16'(q), 16'h0);
    endtask

    task automatic t_local_regs;
        logic [7:0] idxs [7] = '{8'h01, 8'h04, 8'h05, 8'h08, 8'h09, 8'h0C, 8'h0D};
        logic [7:0] q;
        for (int i = 0; i < 7; i++) wr_reg(idxs[i], 8'h30 + 8'(i * 17));
        for (int i = 0; i < 7; i++) begin
            rd_reg(idxs[i], q);
            check(q == 8'h30 + 8'(i * 17), "R2 readback", 16'(q), 16'(8'h30 + 8'(i * 17)));
        end
        check(ctl2_o == 8'h30, "R2 ctl2_o", 16'(ctl2_o), 16'h30);
        check(div_a_o == 8'h30 + 8'(5 * 17), "R2 div_a_o", 16'(div_a_o), 16'(8'h30 + 8'(5 * 17)));
        check(div_b_o == 8'h30 + 8'(6 * 17), "R2 div_b_o", 16'(div_b_o), 16'(8'h30 + 8'(6 * 17)));
    endtask

    task automatic t_index_persist;
        logic [7:0] q;
        wr_reg(8'h0C, 8'h3C);
        bus_cycle(1'b0, 1'b0, 8'h00, q);
        check(q == 8'h3C, "R1 second read same index", 16'(q), 16'h3C);
        bus_cycle(1'b0, 1'b1, 8'hC3, q);
        bus_cycle(1'b0, 1'b0, 8'h00, q);
        check(q == 8'hC3, "R1 write then read same index", 16'(q), 16'hC3);
    endtask

    task automatic t_revision;
        logic [7:0] q;
        rd_reg(8'h0F, q);
        check(q == REV_EXP, "R3 revision", 16'(q), 16'(REV_EXP));
        wr_reg(8'h0F, 8'h00);
        rd_reg(8'h0F, q);
        check(q == REV_EXP, "R3 revision after write", 16'(q), 16'(REV_EXP));
    endtask

    task automatic t_unmapped;
        logic [7:0] bad [5] = '{8'h02, 8'h03, 8'h0B, 8'h0E, 8'h80};
        logic [7:0] q;
        wr_reg(8'h04, 8'h11); wr_reg(8'h09, 8'h22); wr_reg(8'h0D, 8'h33);
        for (int i = 0; i < 5; i++) wr_reg(bad[i], 8'hFF);
        for (int i = 0; i < 5; i++) begin
            rd_reg(bad[i], q);
            check(q == 8'h00, "R4 unmapped read", 16'(q), 16'h0);
        end
        rd_reg(8'h04, q); check(q == 8'h11, "R4 reg04 untouched", 16'(q), 16'h11);
        rd_reg(8'h09, q); check(q == 8'h22, "R4 reg09 untouched", 16'(q), 16'h22);
        rd_reg(8'h0D, q); check(q == 8'h33, "R4 reg0D untouched", 16'(q), 16'h33);
        rd_reg(8'h00, q); check(q == 8'h00, "R4 reg00 untouched", 16'(q), 16'h0);
    endtask

    task automatic t_read_timing;
        logic [7:0] q;
        wr_reg(8'h01, 8'hA5);
        rd_reg(8'h01, q);
        check(q == 8'hA5, "R5 data in first cycle", 16'(q), 16'hA5);
        check(last_en == 1'b1, "R5 dout_en during read", 16'(last_en), 16'h1);
        @(negedge clk);
        check(bus_dout_en == 1'b0, "R5 dout_en after release", 16'(bus_dout_en), 16'h0);
        check(first_rdy == 1'b0, "R7 local rdy_n", 16'(first_rdy), 16'h0);
    endtask

    task automatic t_forward;
        logic [7:0] q;
        int n0;
        wr_reg(8'h04, 8'h34); wr_reg(8'h05, 8'h12);
        wr_reg(8'h08, 8'h78); wr_reg(8'h09, 8'h56);
        n0 = n_fwd;
        wr_reg(8'h06, 8'h9E);
        check(first_rdy == 1'b1, "R7 rdy_n high while forwarded", 16'(first_rdy), 16'h1);
        check(n_fwd == n0 + 1, "R6 one request per write", 16'(n_fwd - n0), 16'h1);
        check(log_sel == 1'b0 && log_we == 1'b1, "R6 card write sel/we", {14'd0, log_sel, log_we}, 16'h1);
        check(log_addr == 16'h1234, "R6 card address", log_addr, 16'h1234);
        check(log_wdata == 8'h9E, "R6 card wdata", 16'(log_wdata), 16'h9E);
        rd_reg(8'h0A, q);
        check(log_sel == 1'b1 && log_we == 1'b0, "R6 filter read sel/we", {14'd0, log_sel, log_we}, 16'h2);
        check(log_addr == 16'h5678, "R6 filter address", log_addr, 16'h5678);
        check(q == (8'h78 ^ 8'h5A ^ 8'h01), "R7 filter read data", 16'(q), 16'(8'h78 ^ 8'h5A ^ 8'h01));
        check(last_en == 1'b1, "R7 dout_en on forwarded read", 16'(last_en), 16'h1);
        rd_reg(8'h06, q);
        check(q == (8'h34 ^ 8'h5A), "R7 card read data", 16'(q), 16'(8'h34 ^ 8'h5A));
        check(n_fwd == n0 + 3, "R6 request count", 16'(n_fwd - n0), 16'h3);
    endtask

    task automatic t_irq;
        logic [7:0] q;
        wr_reg(8'h00, 8'h47);
        rd_reg(8'h00, q);
        check(q == 8'h44, "R9 enable readback, low bits ignored", 16'(q), 16'h44);
        check(irq_n == 1'b1, "R8 no irq before change", 16'(irq_n), 16'h1);
        @(negedge clk); card_det_n = 2'b10;
        @(negedge clk);
        check(irq_n == 1'b1, "R8 irq not yet", 16'(irq_n), 16'h1);
        @(negedge clk);
        check(irq_n == 1'b0, "R8 irq asserted slot0", 16'(irq_n), 16'h0);
        rd_reg(8'h07, q);
        check(q == 8'h02, "R11 ctl shows detect", 16'(q), 16'h02);
        rd_reg(8'h00, q);
        check(q == 8'h45, "R9 pending read", 16'(q), 16'h45);
        check(irq_n == 1'b1, "R9 irq released", 16'(irq_n), 16'h1);
        @(negedge clk); card_det_n = 2'b00;
        repeat (3) @(negedge clk);
        check(irq_n == 1'b0, "R8 irq asserted slot1", 16'(irq_n), 16'h0);
        rd_reg(8'h00, q);
        check(q == 8'h46, "R9 slot1 pending read", 16'(q), 16'h46);
        // slot 1 disabled
        wr_reg(8'h00, 8'h04);
        @(negedge clk); card_det_n = 2'b10;
        repeat (4) @(negedge clk);
        check(irq_n == 1'b1, "R10 disabled slot silent", 16'(irq_n), 16'h1);
        rd_reg(8'h00, q);
        check(q == 8'h04, "R10 no pending flag", 16'(q), 16'h04);
    endtask

    task automatic t_ctl;
        logic [7:0] q;
        wr_reg(8'h07, 8'hFF);
        rd_reg(8'h07, q);
        check(q == 8'hFE, "R11 ctl stored bits + detect", 16'(q), 16'hFE);
        check(ctl_o == 8'hFC, "R11 ctl_o low bits ignored", 16'(ctl_o), 16'hFC);
        wr_reg(8'h07, 8'h00);
        rd_reg(8'h07, q);
        check(q == 8'h02, "R11 ctl cleared", 16'(q), 16'h02);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_local_regs();
        t_index_persist();
        t_revision();
        t_unmapped();
        t_read_timing();
        t_forward();
        t_irq();
        t_ctl();
        if (!done) begin
            done = 1;
            $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_chk++; n_bad++;
            $display("FAIL watchdog: got 0x0 expected 0x1");
            $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

endmodule